// File: doc/BRIEF.md
# Always-On Down-Counting Timer

This block is a 32-bit timer whose counter lives in a slow, always-on clock domain (nominally 32768 Hz). A host on a faster bus clock programs it and reads it. Three word registers are visible: a reload value, the live count and a run-mode control. When the mode is set to loop, the counter steps down by one on every slow-clock edge. After it reaches zero it restarts from the reload value, so it cycles forever. When the mode is stopped, the counter is frozen, and writing a new reload value also places that value into the counter.

The reload value crosses into the slow domain through a toggle request/acknowledge handshake. The live count crosses back through a capture scheme. On every counter update the slow side flips a single update bit. The bus side synchronizes that bit and copies the count word while the word is known to be stable. As a result, one bus read always returns a value the counter actually held. Software that inverts the count gets a strictly incrementing time base.

Top module: `aon_downtimer`

## Requirements
- R1: After reset the reload register, the mode register and the readable count are all zero.
- R2: The byte offset 0x0 maps the reload register (read/write), 0x4 the count (read-only) and 0x8 the mode register. A read of any other offset returns zero. Read data appears on `bus_rdata` on the bus-clock edge that follows the read cycle.
- R3: Writing exactly 0x1 to the mode register selects looping operation and reads back as 0x1. Writing any other value selects stopped operation and reads back as 0x0.
- R4: While looping, a nonzero count decreases by exactly one on each slow-clock edge, with no skipped values.
- R5: While looping, a count of zero is replaced on the next slow-clock edge by the reload value that the slow domain holds.
- R6: While stopped, the count holds its value across slow-clock edges.
- R7: A reload write made while stopped also loads the counter. The new count is readable within eight slow-clock periods.
- R8: A reload write made while looping leaves the running count undisturbed. The new reload value is used at the next pass through zero.
- R9: Writes to the count offset 0x4 change neither the count nor any register.
- R10: Every value read from offset 0x4 is one the counter held, so successive reads differ only by a legal step. Each counter update becomes readable within one slow-clock period, provided the bus clock is at least four times faster.
- R11: With a reload of 0xFFFFFFFF the counter starts from the top of the 32-bit range, and its first step is to 0xFFFFFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| slow_clk | input | 1 | Always-on slow reference clock; one count step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |

## Verification
The hardest situation to reach is a reload write that lands while the counter is looping and close to zero. In that case the old and new reload values and the zero crossing all meet within a few slow periods. The bench reaches it in three steps. It arms a small reload of 3 and starts the loop. It then writes a much larger reload while the count is running. Finally it polls the count on every other bus cycle and requires each observed change to be a single decrement or a reload from zero, with 0x50 eventually appearing. A load at the wrong moment or a torn capture then shows up as an illegal step.

// File: rtl/aon_tmr_pkg.sv
package aon_tmr_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 4'h8;
  localparam int unsigned MODE_LOOP_CODE = 1;
endpackage

// File: rtl/aon_tmr_rst_sync.sv
module aon_tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/aon_tmr_bit_sync.sv
module aon_tmr_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/aon_tmr_core.sv
module aon_tmr_core #(
  parameter int CNT_W  = 32,
  parameter int STAGES = 2
) (
  input  logic             slow_clk,
  input  logic             slow_rst_n,
  input  logic             run_async,
  input  logic             ld_req_async,
  input  logic [CNT_W-1:0] ld_data,
  output logic             ld_ack_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             upd_tgl_o,
  output logic             run_o,
  output logic             ld_pulse_o
);
  logic run_s, req_s, req_d_q;
  logic ld_pulse;
  logic [CNT_W-1:0] cnt_q, cnt_d, reload_q, reload_d;
  logic cnt_en;
  logic upd_q, upd_d;

  aon_tmr_bit_sync #(.STAGES(STAGES)) u_run_sync (
    .clk(slow_clk), .rst_n(slow_rst_n), .d(run_async), .q(run_s)
  );
  aon_tmr_bit_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(slow_clk), .rst_n(slow_rst_n), .d(ld_req_async), .q(req_s)
  );

  assign ld_pulse = req_s ^ req_d_q;

  // next state
  always_comb begin
    reload_d = ld_pulse ? ld_data : reload_q;
    cnt_en   = 1'b0;
    cnt_d    = cnt_q;
    if (run_s) begin
      cnt_en = 1'b1;
      cnt_d  = (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
    end else if (ld_pulse) begin
      cnt_en = 1'b1;
      cnt_d  = ld_data;
    end
    upd_d = upd_q ^ cnt_en;
  end

  // registers
  always_ff @(posedge slow_clk or negedge slow_rst_n) begin
    if (!slow_rst_n) begin
      req_d_q  <= 1'b0;
      reload_q <= '0;
      cnt_q    <= '0;
      upd_q    <= 1'b0;
    end else begin
      req_d_q  <= req_s;
      reload_q <= reload_d;
      if (cnt_en) cnt_q <= cnt_d;
      upd_q    <= upd_d;
    end
  end

  assign ld_ack_o   = req_d_q;
  assign cnt_o      = cnt_q;
  assign reload_o   = reload_q;
  assign upd_tgl_o  = upd_q;
  assign run_o      = run_s;
  assign ld_pulse_o = ld_pulse;
endmodule

// File: rtl/aon_downtimer.sv
module aon_downtimer
  import aon_tmr_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              slow_clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata
);
  localparam logic [CNT_W-1:0] MODE_LOOP = CNT_W'(MODE_LOOP_CODE);

  logic b_rst_n, s_rst_n;

  logic [CNT_W-1:0] reload_q, reload_d;
  logic             mode_q, mode_d;
  logic [CNT_W-1:0] xfer_q, xfer_d;
  logic             req_q, req_d, pend_q, pend_d;
  logic             ack_s, upd_s, upd_seen_q;
  logic [CNT_W-1:0] bcnt_q, bcnt_d;
  logic [CNT_W-1:0] rdata_q, rdata_d, rd_mux;
  logic             wr_reload, wr_mode, rd_acc, busy, launch, cap;

  logic [CNT_W-1:0] cnt_slow, reload_slow;
  logic             ack_slow, upd_slow, run_slow, ld_pulse_slow;

  aon_tmr_rst_sync #(.STAGES(SYNC_STAGES)) u_brst (
    .clk(bus_clk), .arst_n(rst_n), .rst_n_o(b_rst_n)
  );
  aon_tmr_rst_sync #(.STAGES(SYNC_STAGES)) u_srst (
    .clk(slow_clk), .arst_n(rst_n), .rst_n_o(s_rst_n)
  );

  aon_tmr_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(bus_clk), .rst_n(b_rst_n), .d(ack_slow), .q(ack_s)
  );
  aon_tmr_bit_sync #(.STAGES(SYNC_STAGES)) u_upd_sync (
    .clk(bus_clk), .rst_n(b_rst_n), .d(upd_slow), .q(upd_s)
  );

  aon_tmr_core #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_core (
    .slow_clk    (slow_clk),
    .slow_rst_n  (s_rst_n),
    .run_async   (mode_q),
    .ld_req_async(req_q),
    .ld_data     (xfer_q),
    .ld_ack_o    (ack_slow),
    .cnt_o       (cnt_slow),
    .reload_o    (reload_slow),
    .upd_tgl_o   (upd_slow),
    .run_o       (run_slow),
    .ld_pulse_o  (ld_pulse_slow)
  );

  // next state, bus domain
  always_comb begin
    wr_reload = bus_sel && bus_wr && (bus_addr == OFS_RELOAD);
    wr_mode   = bus_sel && bus_wr && (bus_addr == OFS_MODE);
    rd_acc    = bus_sel && !bus_wr;
    busy      = req_q ^ ack_s;
    launch    = (wr_reload || pend_q) && !busy;

    reload_d = wr_reload ? bus_wdata : reload_q;
    mode_d   = wr_mode ? (bus_wdata == MODE_LOOP) : mode_q;
    xfer_d   = launch ? reload_d : xfer_q;
    req_d    = req_q ^ launch;
    pend_d   = launch ? 1'b0 : (pend_q || wr_reload);

    cap    = upd_s ^ upd_seen_q;
    bcnt_d = cap ? cnt_slow : bcnt_q;

    unique case (bus_addr)
      OFS_RELOAD: rd_mux = reload_q;
      OFS_COUNT:  rd_mux = bcnt_q;
      OFS_MODE:   rd_mux = {{(CNT_W-1){1'b0}}, mode_q};
      default:    rd_mux = '0;
    endcase
    rdata_d = rd_acc ? rd_mux : rdata_q;
  end

  // registers, bus domain
  always_ff @(posedge bus_clk or negedge b_rst_n) begin
    if (!b_rst_n) begin
      reload_q   <= '0;
      mode_q     <= 1'b0;
      xfer_q     <= '0;
      req_q      <= 1'b0;
      pend_q     <= 1'b0;
      upd_seen_q <= 1'b0;
      bcnt_q     <= '0;
      rdata_q    <= '0;
    end else begin
      reload_q   <= reload_d;
      mode_q     <= mode_d;
      if (launch) xfer_q <= xfer_d;
      req_q      <= req_d;
      pend_q     <= pend_d;
      upd_seen_q <= upd_s;
      if (cap) bcnt_q <= bcnt_d;
      rdata_q    <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/aon_downtimer_chk.sv
module aon_downtimer_chk #(
  parameter int CNT_W = 32
) (
  input logic             bus_clk,
  input logic             slow_clk,
  input logic             b_rst_n,
  input logic             s_rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [3:0]       bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [CNT_W-1:0] bus_rdata,
  input logic [CNT_W-1:0] reload_q,
  input logic             mode_q,
  input logic [CNT_W-1:0] cnt_slow,
  input logic [CNT_W-1:0] reload_slow,
  input logic             run_slow,
  input logic             ld_pulse_slow
);
  assert_unmapped_R2: assert property (@(posedge bus_clk) disable iff (!b_rst_n)
    (bus_sel && !bus_wr && bus_addr != 4'h0 && bus_addr != 4'h4 && bus_addr != 4'h8)
    |=> bus_rdata == '0);

  assert_mode_code_R3: assert property (@(posedge bus_clk) disable iff (!b_rst_n)
    (bus_sel && bus_wr && bus_addr == 4'h8)
    |=> mode_q == ($past(bus_wdata) == CNT_W'(1)));

  assert_step_R4: assert property (@(posedge slow_clk) disable iff (!s_rst_n)
    (run_slow && cnt_slow != '0) |=> cnt_slow == $past(cnt_slow) - 1'b1);

  assert_reload_R5: assert property (@(posedge slow_clk) disable iff (!s_rst_n)
    (run_slow && cnt_slow == '0) |=> cnt_slow == $past(reload_slow));

  assert_hold_R6: assert property (@(posedge slow_clk) disable iff (!s_rst_n)
    (!run_slow && !ld_pulse_slow) |=> $stable(cnt_slow));

  assert_count_wr_ignored_R9: assert property (@(posedge bus_clk) disable iff (!b_rst_n)
    (bus_sel && bus_wr && bus_addr == 4'h4) |=> ($stable(reload_q) && $stable(mode_q)));
endmodule

bind aon_downtimer aon_downtimer_chk #(.CNT_W(CNT_W)) u_chk (
  .bus_clk      (bus_clk),
  .slow_clk     (slow_clk),
  .b_rst_n      (b_rst_n),
  .s_rst_n      (s_rst_n),
  .bus_sel      (bus_sel),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .reload_q     (reload_q),
  .mode_q       (mode_q),
  .cnt_slow     (cnt_slow),
  .reload_slow  (reload_slow),
  .run_slow     (run_slow),
  .ld_pulse_slow(ld_pulse_slow)
);

// File: tb/sim_aon_downtimer.sv
module sim_aon_downtimer;
  localparam int BUS_PERIOD  = 10;
  localparam int SLOW_PERIOD = 100;
  localparam int READS_PER_SLOW = SLOW_PERIOD / (2 * BUS_PERIOD);
  localparam logic [3:0] A_RELOAD = 4'h0;
  localparam logic [3:0] A_COUNT  = 4'h4;
  localparam logic [3:0] A_MODE   = 4'h8;

  logic        bus_clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
  always #(SLOW_PERIOD/2) slow_clk = ~slow_clk;

  aon_downtimer u0 (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge bus_clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_slow(input int n);
    repeat (n) @(posedge slow_clk);
  endtask

  // polls the count; each change must be a single decrement or a reload from zero
  task automatic poll_run(input int nreads, input logic [31:0] ref_a, input logic [31:0] ref_b,
                          input string req, output int changes, output bit saw_zero,
                          output logic [31:0] first_chg);
    logic [31:0] prev, cur, bad_prev, bad_cur;
    int bad;
    bad = 0; changes = 0; saw_zero = 1'b0; first_chg = 32'h0;
    bad_prev = 32'h0; bad_cur = 32'h0;
    bus_read(A_COUNT, prev);
    for (int i = 0; i < nreads; i++) begin
      bus_read(A_COUNT, cur);
      if (cur != prev) begin
        if (changes == 0) first_chg = cur;
        changes++;
        if (prev == 32'h0) saw_zero = 1'b1;
        if (!((cur == prev - 32'h1) || (prev == 32'h0 && (cur == ref_a || cur == ref_b)))) begin
          if (bad == 0) begin bad_prev = prev; bad_cur = cur; end
          bad++;
        end
      end
      prev = cur;
    end
    check(bad == 0, req, bad_cur, bad_prev - 32'h1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_read(A_RELOAD, d); check(d == 32'h0, "R1 reload", d, 32'h0);
    bus_read(A_MODE, d);   check(d == 32'h0, "R1 mode", d, 32'h0);
    bus_read(A_COUNT, d);  check(d == 32'h0, "R1 count", d, 32'h0);
    bus_read(4'hC, d);     check(d == 32'h0, "R2 unmapped 0xC", d, 32'h0);
  endtask

  task automatic t_load_stopped;
    logic [31:0] d;
    bus_write(A_RELOAD, 32'd100);
    bus_read(A_RELOAD, d); check(d == 32'd100, "R2 reload readback", d, 32'd100);
    wait_slow(8);
    bus_read(A_COUNT, d); check(d == 32'd100, "R7 load while stopped", d, 32'd100);
    wait_slow(10);
    bus_read(A_COUNT, d); check(d == 32'd100, "R6 hold while stopped", d, 32'd100);
    bus_read(4'h2, d); check(d == 32'h0, "R2 unmapped 0x2", d, 32'h0);
  endtask

  task automatic t_count_write;
    logic [31:0] d;
    bus_write(A_COUNT, 32'd5);
    wait_slow(8);
    bus_read(A_COUNT, d);  check(d == 32'd100, "R9 count write ignored", d, 32'd100);
    bus_read(A_RELOAD, d); check(d == 32'd100, "R9 reload untouched", d, 32'd100);
    bus_read(A_MODE, d);   check(d == 32'h0, "R9 mode untouched", d, 32'h0);
  endtask

  task automatic t_wrap;
    logic [31:0] d, f;
    int ch; bit z;
    bus_write(A_RELOAD, 32'd3);
    wait_slow(8);
    bus_read(A_COUNT, d); check(d == 32'd3, "R7 reload 3 loaded", d, 32'd3);
    bus_write(A_MODE, 32'h1);
    bus_read(A_MODE, d); check(d == 32'h1, "R3 loop code reads 1", d, 32'h1);
    wait_slow(4);
    poll_run(10 * READS_PER_SLOW, 32'd3, 32'd3, "R4 R10 legal steps", ch, z, f);
    check(ch >= 8 && ch <= 11, "R4 one step per slow tick", ch, 10);
    check(z, "R5 reload from zero seen", {31'h0, z}, 32'h1);
  endtask

  task automatic t_reload_running;
    logic [31:0] f;
    int ch; bit z;
    bus_write(A_RELOAD, 32'h50);
    poll_run(12 * READS_PER_SLOW, 32'd3, 32'h50, "R8 running count undisturbed", ch, z, f);
    wait_slow(1);
    poll_run(3 * READS_PER_SLOW, 32'h50, 32'h50, "R8 R10 legal steps", ch, z, f);
    check(ch >= 2, "R8 still counting", ch, 3);
  endtask

  task automatic t_saw_new_reload;
    logic [31:0] d;
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < 12 * READS_PER_SLOW; i++) begin
      bus_read(A_COUNT, d);
      if (d > 32'd3 && d <= 32'h50) seen = 1'b1;
    end
    check(seen, "R8 new reload used after zero", {31'h0, seen}, 32'h1);
  endtask

  task automatic t_stop_other_code;
    logic [31:0] d, a;
    bus_write(A_MODE, 32'h2);
    bus_read(A_MODE, d); check(d == 32'h0, "R3 non-loop code reads 0", d, 32'h0);
    wait_slow(8);
    bus_read(A_COUNT, a);
    wait_slow(10);
    bus_read(A_COUNT, d); check(d == a, "R6 frozen after mode 2", d, a);
  endtask

  task automatic t_full_range;
    logic [31:0] d, f;
    int ch; bit z;
    bus_write(A_RELOAD, 32'hFFFF_FFFF);
    wait_slow(8);
    bus_read(A_COUNT, d); check(d == 32'hFFFF_FFFF, "R11 full-range load", d, 32'hFFFF_FFFF);
    bus_write(A_MODE, 32'h1);
    poll_run(8 * READS_PER_SLOW, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 R11 legal steps", ch, z, f);
    check(f == 32'hFFFF_FFFE, "R11 first step", f, 32'hFFFF_FFFE);
    check(~f == 32'h1, "R11 inverse increments", ~f, 32'h1);
  endtask

  initial begin
    #(BUS_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(SLOW_PERIOD * 2 + 3);
    rst_n = 1'b1;
    wait_slow(5);
    t_reset();
    t_load_stopped();
    t_count_write();
    t_wrap();
    t_reload_running();
    t_saw_new_reload();
    t_stop_other_code();
    t_full_range();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule